// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block sits between a microprocessor bus and 24 general-purpose I/O lines. The lines form two 8-bit ports, A and B, and an 8-bit port C that is handled as two 4-bit halves. The upper half of C is grouped with port A and the lower half with port B. The CPU reaches a port or the control register through a two-bit address, an active-low chip select, and active-low read and write strobes. Each port presents its output latch, a per-bit output enable and its live input levels.

A control write with the top data bit set is a mode word. It sets the direction of the four groups independently and clears every output latch. A control write with the top bit clear changes one bit of port C and leaves the other bits alone. The CPU can read the control word back at the control address. Only the simple I/O mode exists, so the mode-select fields are forced to zero when they are stored.

The data bus is split into an input half and an output half with a drive enable, so that a pad ring or a bus fabric can build the tri-state bus from it. Everything is clocked by a system clock, and the CPU strobes are sampled against that clock.

Top module: `ppi_port_ctrl`

## Requirements
- R1: The address selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A read at address 3 returns the stored control word.
- R2: A write is committed only on the first clock edge where the write strobe is seen high, after at least one edge where the chip select and the write strobe were both low. The commit uses the address and data from the last edge of the low phase. No port output changes while the write strobe is held low.
- R3: `d_oe` is high exactly when the chip select and the read strobe are both low. `d_out` is zero whenever `d_oe` is low.
- R4: Reset stores control word 0x9B, which puts all four groups in input mode. Reset also clears every output latch and drops every output enable.
- R5: In a mode word, bit 4 sets the direction of port A, bit 3 upper C, bit 1 port B and bit 0 lower C, with 1 meaning input. A group's output enables are all high when it is an output and all low when it is an input.
- R6: In a mode word, bits 6:5 and bit 2 are stored as zero, and bit 7 reads back as one.
- R7: Writing a mode word clears the output latches of ports A, B and C.
- R8: A control write with bit 7 clear writes data bit 0 into the port C bit selected by data bits 3:1. The other port C bits and the control word keep their values.
- R9: A read of a port in input mode returns its live input levels, and a read of a port in output mode returns its latch. A read of port C combines the two halves bit by bit according to each half's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select |
| d_in | input | 8 | Write data from the CPU |
| d_out | output | 8 | Read data to the CPU |
| d_oe | output | 1 | Read data drive enable |
| pa_in | input | 8 | Port A input levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B input levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C input levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest case to reach from the ports is a port C read where the two halves point in opposite directions. In that case the read value must take four bits from the latch and four from the live pins. To get there, the stimulus writes a mode word that splits C, writes a known latch pattern, and drives the pins to a different pattern, so that each bit shows where it came from. A second hard case is a write strobe held low across several clock edges. The bench stretches that phase and checks that the latch changes only after release.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int DW     = 8;
    localparam int HALF_W = DW / 2;
    localparam int AW     = 2;
    localparam int BIT_W  = $clog2(DW);

    typedef enum logic [AW-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    // field positions matter: the CPU writes and reads this layout
    typedef struct packed {
        logic       is_mode;
        logic [1:0] grp_a_mode;
        logic       a_input;
        logic       cu_input;
        logic       grp_b_mode;
        logic       b_input;
        logic       cl_input;
    } ctrl_t;

    typedef struct packed {
        logic          valid;
        sel_e          sel;
        logic [DW-1:0] data;
    } wr_evt_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(8'h9B);

    // only the simple I/O mode is honoured
    function automatic ctrl_t sanitize(input logic [DW-1:0] raw);
        ctrl_t c;
        c            = ctrl_t'(raw);
        c.is_mode    = 1'b1;
        c.grp_a_mode = 2'b00;
        c.grp_b_mode = 1'b0;
        return c;
    endfunction

    function automatic logic [DW-1:0] pick(input logic [DW-1:0] latch,
                                           input logic [DW-1:0] pins,
                                           input logic [DW-1:0] oe);
        return (latch & oe) | (pins & ~oe);
    endfunction

endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] d_in,
    output wr_evt_t       evt
);
    logic          hold_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          active;

    assign active = !cs_n && !wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            hold_q <= active;
            if (active) begin
                addr_q <= addr;
                data_q <= d_in;
            end
        end
    end

    always_comb begin
        evt.valid = hold_q && wr_n;
        evt.sel   = sel_e'(addr_q);
        evt.data  = data_q;
    end
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wr_evt_t       evt,
    output ctrl_t         ctrl,
    output logic [DW-1:0] pa_lat,
    output logic [DW-1:0] pb_lat,
    output logic [DW-1:0] pc_lat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
        end else if (evt.valid) begin
            unique case (evt.sel)
                SEL_A: pa_lat <= evt.data;
                SEL_B: pb_lat <= evt.data;
                SEL_C: pc_lat <= evt.data;
                SEL_CTRL: begin
                    if (evt.data[DW-1]) begin
                        ctrl   <= sanitize(evt.data);
                        pa_lat <= '0;
                        pb_lat <= '0;
                        pc_lat <= '0;
                    end else begin
                        pc_lat[evt.data[BIT_W:1]] <= evt.data[0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
    import ppi_pkg::*;
(
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] pa_lat,
    input  logic [DW-1:0] pb_lat,
    input  logic [DW-1:0] pc_lat,
    input  logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_oe,
    input  logic [DW-1:0] pa_in,
    input  logic [DW-1:0] pb_in,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] d_out
);
    logic [DW-1:0] sel_val;

    always_comb begin
        unique case (sel_e'(addr))
            SEL_A:    sel_val = pick(pa_lat, pa_in, pa_oe);
            SEL_B:    sel_val = pick(pb_lat, pb_in, pb_oe);
            SEL_C:    sel_val = pick(pc_lat, pc_in, pc_oe);
            SEL_CTRL: sel_val = ctrl;
            default:  sel_val = '0;
        endcase
        d_out = rd_en ? sel_val : '0;
    end
endmodule

// File: rtl/ppi_port_ctrl.sv
module ppi_port_ctrl
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [7:0]    d_in,
    output logic [7:0]    d_out,
    output logic          d_oe,
    input  logic [7:0]    pa_in,
    output logic [7:0]    pa_out,
    output logic [7:0]    pa_oe,
    input  logic [7:0]    pb_in,
    output logic [7:0]    pb_out,
    output logic [7:0]    pb_oe,
    input  logic [7:0]    pc_in,
    output logic [7:0]    pc_out,
    output logic [7:0]    pc_oe
);
    wr_evt_t evt;
    ctrl_t   ctrl;

    ppi_bus_if u_bus (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .wr_n (wr_n),
        .addr (addr),
        .d_in (d_in),
        .evt  (evt)
    );

    ppi_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .ctrl   (ctrl),
        .pa_lat (pa_out),
        .pb_lat (pb_out),
        .pc_lat (pc_out)
    );

    assign pa_oe = {DW{!ctrl.a_input}};
    assign pb_oe = {DW{!ctrl.b_input}};
    assign pc_oe = {{HALF_W{!ctrl.cu_input}}, {HALF_W{!ctrl.cl_input}}};
    assign d_oe  = !cs_n && !rd_n;

    ppi_read_mux u_rmux (
        .rd_en  (d_oe),
        .addr   (addr),
        .ctrl   (ctrl),
        .pa_lat (pa_out),
        .pb_lat (pb_out),
        .pc_lat (pc_out),
        .pa_oe  (pa_oe),
        .pb_oe  (pb_oe),
        .pc_oe  (pc_oe),
        .pa_in  (pa_in),
        .pb_in  (pb_in),
        .pc_in  (pc_in),
        .d_out  (d_out)
    );
endmodule

// File: rtl/ppi_port_ctrl_chk.sv
module ppi_port_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] d_out,
    input logic       d_oe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    p_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!d_oe && d_out == 8'h00));

    p_reset_state_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                        pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    p_hold_low_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    p_group_oe_r5: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) &&
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

    p_ctrl_readback_r6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && addr == 2'd3) |->
            (d_out[7] && d_out[6:5] == 2'b00 && !d_out[2]));
endmodule

bind ppi_port_ctrl ppi_port_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .d_out  (d_out),
    .d_oe   (d_oe),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .pc_out (pc_out),
    .pc_oe  (pc_oe)
);

// File: tb/ppi_port_ctrl_test.sv
`timescale 1ns/1ps
module ppi_port_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ppi_port_ctrl uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // write completes on the posedge after wr_n rises; returns at a negedge
    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d, input int low_cycles);
        @(negedge clk);
        cs_n = 1'b0; addr = a; d_in = d; wr_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #2;
        d = d_out;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R4 pa_oe", pa_oe, 8'h00);
        check("R4 pb_oe", pb_oe, 8'h00);
        check("R4 pc_oe", pc_oe, 8'h00);
        check("R4 pc_out", pc_out, 8'h00);
        check("R3 idle d_oe", {7'd0, d_oe}, 8'h00);
        cpu_read(2'd3, v);
        check("R4 R1 ctrl readback", v, 8'h9B);
    endtask

    task automatic t_bus_enable();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
        #2;
        check("R3 no cs d_oe", {7'd0, d_oe}, 8'h00);
        check("R3 no cs d_out", d_out, 8'h00);
        cs_n = 1'b0;
        #2;
        check("R3 cs+rd d_oe", {7'd0, d_oe}, 8'h01);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_outputs();
        logic [7:0] v;
        cpu_write(2'd3, 8'h80, 1);
        check("R5 pa_oe out", pa_oe, 8'hFF);
        check("R5 pb_oe out", pb_oe, 8'hFF);
        check("R5 pc_oe out", pc_oe, 8'hFF);
        cpu_write(2'd0, 8'h5A, 1);
        cpu_write(2'd1, 8'hC3, 1);
        cpu_write(2'd2, 8'h96, 1);
        check("R1 pa_out", pa_out, 8'h5A);
        check("R1 pb_out", pb_out, 8'hC3);
        check("R1 pc_out", pc_out, 8'h96);
        pa_in = 8'h11;
        cpu_read(2'd0, v);
        check("R9 out port reads latch", v, 8'h5A);
        cpu_read(2'd1, v);
        check("R1 R9 port B read", v, 8'hC3);
    endtask

    task automatic t_hold_low();
        @(negedge clk);
        cs_n = 1'b0; addr = 2'd0; d_in = 8'h77; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 held low no change", pa_out, 8'h5A);
        d_in = 8'h3E;
        @(negedge clk);
        wr_n = 1'b1;
        check("R2 before release edge", pa_out, 8'h5A);
        @(negedge clk);
        cs_n = 1'b1;
        check("R2 committed last data", pa_out, 8'h3E);
    endtask

    task automatic t_mixed();
        logic [7:0] v;
        cpu_write(2'd3, 8'h91, 1);
        check("R7 pa cleared", pa_out, 8'h00);
        check("R7 pb cleared", pb_out, 8'h00);
        check("R7 pc cleared", pc_out, 8'h00);
        check("R5 pa_oe in", pa_oe, 8'h00);
        check("R5 pb_oe out", pb_oe, 8'hFF);
        check("R5 pc_oe split", pc_oe, 8'hF0);
        pa_in = 8'h3C;
        pc_in = 8'hFF;
        cpu_read(2'd0, v);
        check("R9 input port reads pins", v, 8'h3C);
        cpu_write(2'd2, 8'hA5, 1);
        cpu_read(2'd2, v);
        check("R9 port C mixed halves", v, 8'hAF);
        cpu_read(2'd3, v);
        check("R1 ctrl readback 91", v, 8'h91);
    endtask

    task automatic t_mode_bits();
        logic [7:0] v;
        cpu_write(2'd3, 8'hFF, 1);
        cpu_read(2'd3, v);
        check("R6 mode bits forced zero", v, 8'h9B);
        check("R6 R5 all inputs", pc_oe, 8'h00);
    endtask

    task automatic t_bit_setreset();
        logic [7:0] v;
        cpu_write(2'd3, 8'h80, 1);
        cpu_write(2'd3, 8'h0B, 1);
        check("R8 set bit5", pc_out, 8'h20);
        cpu_write(2'd3, 8'h01, 1);
        check("R8 set bit0", pc_out, 8'h21);
        cpu_write(2'd3, 8'h0F, 1);
        check("R8 set bit7", pc_out, 8'hA1);
        cpu_write(2'd3, 8'h0A, 1);
        check("R8 clear bit5", pc_out, 8'h81);
        check("R8 pa untouched", pa_out, 8'h00);
        cpu_read(2'd3, v);
        check("R8 ctrl unchanged", v, 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bus_enable();
        t_outputs();
        t_hold_low();
        t_mixed();
        t_mode_bits();
        t_bit_setreset();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule